// File: doc/BRIEF.md
# Parallel Host Bus Burst Reader

This block is a slave on an asynchronous, Intel-style parallel host bus. It serves reads and writes to a 128-entry register file of 8-bit registers. The host strobes are active low: chip select `cs_n`, read strobe `rd_n` and write strobe `wr_n`. An active-high address latch enable `ale` captures a 7-bit address, and data moves over an 8-bit bidirectional bus. A ready output tells the host when read data can be taken.

The host latches a start address once with `ale`. The first read strobe after that returns the latched location. Each later read strobe, while `ale` stays low, first advances the internal address by one and then returns that location. This happens whatever value is on the address pins. The address wraps from 0x7F to 0x00. All host inputs pass through a two-flop synchroniser into the system clock domain.

A controller moves through four states:
- IDLE: waits for a synchronised read or write with chip select low. It also reloads the address whenever `ale` is high.
- RD_WAIT: holds ready low for a fixed access latency (transition IDLE→RD_WAIT on a read start).
- RD_DONE: drives the bus and raises ready (RD_WAIT→RD_DONE when the latency expires). It returns to IDLE when the synchronised read strobe goes high (RD_DONE→IDLE).
- WR: captures the bus while the write strobe is low (IDLE→WR). It commits the data to the latched address when the strobe rises (WR→IDLE).

Top module: `hostbus_burst_rd`

## Requirements
- R1: After reset, `rdy` is high, the data bus is not driven, and register i (0..127) holds {1'b0,i} XOR 8'hA5.
- R2: The first read after an `ale` high phase returns the register at the address that was on `addr` while `ale` was high.
- R3: Each later read in the same burst (`ale` kept low) returns the register at the previous read address plus one, even when the `addr` pins change.
- R4: The burst address wraps from 0x7F to 0x00.
- R5: `rdy` goes low combinationally as soon as `cs_n` and `rd_n` are both low. It rises at the fifth rising clock edge after `rd_n` falls: two synchroniser stages, one decision edge, then a latency of two clocks. Once `rdy` is high, the bus carries the read data.
- R6: The block does not drive the data bus while `cs_n` or `rd_n` is high. It also does not drive the bus during a read before `rdy` rises.
- R7: While `cs_n` is high, read and write strobes are ignored. `rdy` stays high, the burst address does not advance and no register is written.
- R8: A write strobe writes the data bus into the register at the latched address when the strobe ends. A write does not advance the burst address, so the next read returns the same location it would have returned without the write.
- R9: A new `ale` phase in the middle of a burst reloads the address and starts a new burst from it.
- R10: If `ale` and a read start are recognised in the same synchronised cycle, the read uses the newly presented address. The read after it returns that address plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch enable, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 7 | Register address, sampled while `ale` is high |
| data | inout | 8 | Bidirectional data bus |
| rdy | output | 1 | Ready: low while a read is pending, high when data is valid or no read is active |

## Verification
Two functions can land in one synchronised cycle: an address reload from `ale` and the start of a read strobe. The bench provokes this by raising `ale` and pulling `rd_n` low on the same clock edge with a fresh address. It then expects that read to return the new address and the following burst read to return the address plus one. If the design used the stale burst address, or reloaded after the read and marked a fresh burst, one of the two scoreboard comparisons would fail.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_RD_DONE = 2'd2,
        ST_WR      = 2'd3
    } hbr_state_e;

endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile #(
    parameter int             AW       = 7,
    parameter int             DW       = 8,
    parameter logic [DW-1:0]  INIT_KEY = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] rows [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_row
            logic [DW-1:0] row_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    row_q <= DW'(g) ^ INIT_KEY;
                else if (we && waddr == AW'(g))
                    row_q <= wdata;
            end
            assign rows[g] = row_q;
        end
    endgenerate

    assign rdata = rows[raddr];

    AST_WR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rows[$past(waddr)] == $past(wdata)); // R8

endmodule

// File: rtl/hostbus_burst_rd.sv
module hostbus_burst_rd #(
    parameter int            AW       = 7,
    parameter int            DW       = 8,
    parameter int            RD_LAT   = 2,
    parameter int            SYNC_N   = 2,
    parameter logic [DW-1:0] INIT_KEY = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    inout  wire  [DW-1:0] data,
    output logic          rdy
);

    import hbr_pkg::*;

    localparam int CW = $clog2(RD_LAT + 1);
    localparam int SW = AW + 4;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, {AW{1'b0}}};

    // synchronised host inputs
    logic [SW-1:0] sync_q;
    logic          ale_s, cs_n_s, rd_n_s, wr_n_s;
    logic [AW-1:0] addr_s;

    hbr_sync #(.W(SW), .STAGES(SYNC_N), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ale, cs_n, rd_n, wr_n, addr}),
        .q     (sync_q)
    );

    assign {ale_s, cs_n_s, rd_n_s, wr_n_s, addr_s} = sync_q;

    hbr_state_e    state, nxt;
    logic [AW-1:0] addr_q;
    logic          first_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] dout_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rf_rdata;
    logic [AW-1:0] start_addr;
    logic          rd_go, wr_go, rf_we, bus_oe;

    assign rd_go = !cs_n_s && !rd_n_s;
    assign wr_go = !cs_n_s && !wr_n_s;

    // a fresh ALE wins over the burst step; otherwise step unless first read
    assign start_addr = ale_s   ? addr_s :
                        first_q ? addr_q : addr_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_go)      nxt = ST_RD_WAIT;
                else if (wr_go) nxt = ST_WR;
            end
            ST_RD_WAIT: if (cnt_q == '0) nxt = ST_RD_DONE;
            ST_RD_DONE: if (rd_n_s)      nxt = ST_IDLE;
            ST_WR:      if (wr_n_s)      nxt = ST_IDLE;
        endcase
    end

    // address, latency counter and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            first_q <= 1'b1;
            cnt_q   <= '0;
            dout_q  <= '0;
            wdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rd_go) begin
                        addr_q  <= start_addr;
                        first_q <= 1'b0;
                        cnt_q   <= CW'(RD_LAT - 1);
                    end else if (ale_s) begin
                        addr_q  <= addr_s;
                        first_q <= 1'b1;
                    end
                end
                ST_RD_WAIT: begin
                    if (cnt_q != '0) cnt_q  <= cnt_q - 1'b1;
                    else             dout_q <= rf_rdata;
                end
                ST_RD_DONE: ;
                ST_WR: if (!wr_n_s) wdata_q <= data;
            endcase
        end
    end

    assign rf_we = (state == ST_WR) && wr_n_s;

    hbr_regfile #(.AW(AW), .DW(DW), .INIT_KEY(INIT_KEY)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (addr_q),
        .wdata (wdata_q),
        .raddr (addr_q),
        .rdata (rf_rdata)
    );

    // host-facing outputs
    assign bus_oe = !cs_n && !rd_n && (state == ST_RD_DONE);
    assign rdy    = !(!cs_n && !rd_n) || (state == ST_RD_DONE);
    assign data   = bus_oe ? dout_q : {DW{1'bz}};

    // assertion support: cycles spent waiting for the access
    logic [CW-1:0] lat_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  lat_seen <= '0;
        else if (state == ST_RD_WAIT) lat_seen <= lat_seen + 1'b1;
        else                         lat_seen <= '0;
    end

    AST_READY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_DONE && $past(state) == ST_RD_WAIT) |-> lat_seen == CW'(RD_LAT)); // R5

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rd_go && !ale_s && !first_q)
            |=> addr_q == AW'($past(addr_q) + 1'b1)); // R3

    AST_WR_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR) |=> $stable(addr_q)); // R8

    AST_CS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cs_n_s) |=> state == ST_IDLE); // R7

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> !bus_oe); // R6

endmodule

// File: tb/tb_hostbus_burst_rd.sv
module tb_hostbus_burst_rd;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [6:0] addr = '0;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_d = '0;
    wire  [7:0] data;
    wire        rdy;

    assign data = tb_oe ? tb_d : 8'hzz;

    always #4 clk = ~clk;

    hostbus_burst_rd dut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .addr(addr), .data(data), .rdy(rdy)
    );

    int         checks = 0, fails = 0, cyc = 0;
    logic [7:0] model [128];
    logic [7:0] expq [$];
    string      tagq [$];
    bit         taken = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor: one comparison per read strobe once ready is high
    always @(negedge clk) begin
        logic [7:0] e;
        string      t;
        if (rd_n) taken = 1'b0;
        else if (!cs_n && rdy && !taken) begin
            taken = 1'b1;
            if (expq.size() == 0) chk(1'b0, "R2 unexpected read", data, 8'h00);
            else begin
                e = expq.pop_front();
                t = tagq.pop_front();
                chk(data === e, t, data, e);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            checks++; fails++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 60000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic bus_quiet(input string req);
        tb_d = 8'h00; tb_oe = 1'b1;
        #1 chk(data === 8'h00, req, data, 8'h00);
        tb_oe = 1'b0;
    endtask

    task automatic set_addr(input logic [6:0] a);
        @(negedge clk); ale = 1'b1; addr = a;
        repeat (4) @(negedge clk);
        ale = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(input logic [6:0] loc, input string tag,
                           input bit with_ale = 1'b0, input logic [6:0] na = '0);
        expq.push_back(model[loc]);
        tagq.push_back(tag);
        @(negedge clk);
        if (with_ale) begin ale = 1'b1; addr = na; end
        rd_n = 1'b0;
        #1 chk(rdy == 1'b0, "R5 rdy low on strobe", {7'd0, rdy}, 8'd0);
        bus_quiet("R6 bus idle before ready");
        repeat (4) @(posedge clk);
        @(negedge clk) chk(rdy == 1'b0, "R5 rdy still low at edge 4", {7'd0, rdy}, 8'd0);
        @(posedge clk);
        @(negedge clk) chk(rdy == 1'b1, "R5 rdy high at edge 5", {7'd0, rdy}, 8'd1);
        ale = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk); tb_d = v; tb_oe = 1'b1; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        tb_oe = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) model[i] = {1'b0, 7'(i)} ^ 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy == 1'b1, "R1 rdy after reset", {7'd0, rdy}, 8'd1);
        bus_quiet("R1 bus idle after reset");
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_quiet("R6 bus idle with rd_n high");

        // R2 / R3: start at 0, then burst with changing address pins
        set_addr(7'h00);
        do_read(7'h00, "R2 first read");
        addr = 7'h55;
        do_read(7'h01, "R3 burst +1");
        addr = 7'h0A;
        do_read(7'h02, "R3 burst +2");

        // R4: wrap
        set_addr(7'h7E);
        do_read(7'h7E, "R2 first read 0x7E");
        do_read(7'h7F, "R4 burst 0x7F");
        do_read(7'h00, "R4 wrap to 0x00");

        // R8: write before first read
        set_addr(7'h10);
        do_write(8'h5A); model[7'h10] = 8'h5A;
        do_read(7'h10, "R8 write landed, no advance");
        do_read(7'h11, "R8 burst after write");

        // R8: write in the middle of a burst
        set_addr(7'h20);
        do_read(7'h20, "R2 first read 0x20");
        do_write(8'h77); model[7'h20] = 8'h77;
        do_read(7'h21, "R8 mid-burst write keeps step");

        // R7: strobes with chip select high
        @(negedge clk); cs_n = 1'b1;
        repeat (4) @(negedge clk);
        rd_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(rdy == 1'b1, "R7 rdy high with cs_n high", {7'd0, rdy}, 8'd1);
        bus_quiet("R6 bus idle with cs_n high");
        rd_n = 1'b1;
        do_write(8'hEE);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        do_read(7'h22, "R7 no advance while deselected");
        set_addr(7'h20);
        do_read(7'h20, "R8 write went to latched address");
        do_read(7'h21, "R7 no write while deselected");

        // R9: reload mid-burst
        set_addr(7'h40);
        do_read(7'h40, "R9 reload restarts burst");
        do_read(7'h41, "R9 burst after reload");

        // R10: ALE and read start in the same cycle
        do_read(7'h33, "R10 same-cycle ALE read", 1'b1, 7'h33);
        do_read(7'h34, "R10 burst after same-cycle ALE");

        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R2 all reads observed", 8'(expq.size()), 8'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule